// File: doc/BRIEF.md
# Secure SGI Access Permission Register

This block holds the policy that decides whether software running in the non-secure world may raise a software-generated interrupt (SGI) that belongs to one of the two secure interrupt groups. The policy is one 32-bit control register with a 2-bit code per SGI, 16 SGIs in all. SGI n owns bits [2n+1:2n]. Each code is a permission level, and a higher code never grants less than a lower one.

The register sits behind a simple single-beat bus slave that decodes one byte offset, 0x0E00 by default. Whether an access may touch the register depends on a global security-disable input and on the security state that comes with the access. A second port answers permission queries. A query names an SGI, the group it targets and whether it comes from secure software. One cycle later the port returns an allow or deny decision, computed from the register contents as they stood when the query was sampled. Only SGIs are covered. Private peripheral interrupts are not governed here.

Top module: `sgi_nsacc_reg`

## Requirements
- R1: After reset every field is 0b00. A permitted read returns 0, and a non-secure query for a secure group is denied. Both response valids are low until a request arrives.
- R2: With security-disable low, an access whose state is secure (bus_sec=0) or root (bus_sec=2) at the register offset is read/write. A write takes effect at the sampling edge. A read raises bus_rvalid one cycle after the request, with the stored word on bus_rdata.
- R3: With security-disable low, an access whose state is non-secure (bus_sec=1) or realm (bus_sec=3) reads as zero and leaves the register unchanged.
- R4: With security-disable high, every access reads as zero and every write is ignored, whatever its security state.
- R5: An access at any offset other than the register offset reads as zero and does not change the register.
- R6: On a permitted write, byte lane b (bus_wstrb[b], bits [8b+7:8b]) is updated only when its strobe is set.
- R7: A read returns the stored code unchanged, including a stored 0b11.
- R8: Code 0b00 denies a non-secure query that targets secure group 0 (chk_group=0) or secure group 1 (chk_group=1).
- R9: Code 0b01 allows a non-secure query for secure group 0 and denies one for secure group 1.
- R10: Code 0b10 allows a non-secure query for either secure group. Code 0b11 is decided exactly as 0b10.
- R11: A query whose target group has bit 1 set (non-secure group), or whose chk_from_secure is high, is always allowed.
- R12: A query for SGI n is decided by bits [2n+1:2n] and by no other field. chk_rvalid rises one cycle after chk_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_disable | input | 1 | Global security-disable. When high, all register accesses read as zero and all writes are ignored |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_sec | input | 2 | Security state of the access: 0 secure, 1 non-secure, 2 root, 3 realm |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte write strobes |
| bus_rvalid | output | 1 | Read response valid, one cycle after a read request |
| bus_rdata | output | 32 | Read response data |
| chk_valid | input | 1 | Permission query strobe |
| chk_sgi | input | 4 | SGI number of the query |
| chk_group | input | 2 | Target group: 0 secure group 0, 1 secure group 1, bit 1 set non-secure |
| chk_from_secure | input | 1 | Query comes from secure software |
| chk_rvalid | output | 1 | Decision valid, one cycle after a query |
| chk_allow | output | 1 | 1 = SGI may be generated |

## Verification
The assertions check on every cycle that blocked writes leave the register untouched, whatever blocked them: security state, security-disable or a wrong offset. They also check that blocked reads return zero, that permitted reads return the word stored the cycle before, and that both response valids follow their requests by exactly one cycle. For queries, they check that a zero code always denies and that non-secure-group or secure-origin queries are always allowed. Only the bench scenarios can show that partial strobes merge correctly, that a stored 0b11 reads back raw while being decided as 0b10, and that every SGI index picks its own field. They cover the last point by walking all 16 SGIs against a patterned register for every group and origin.

// File: rtl/sgi_nsacc_pkg.sv
// Package: shared encodings for the secure SGI access permission register.
// Assumes 2-bit permission codes. Higher codes grant a superset of the
// permissions of lower codes.
package sgi_nsacc_pkg;

    localparam int FIELD_W = 2;

    // Security state presented with a bus access
    typedef enum logic [1:0] {
        SEC_SECURE    = 2'd0,
        SEC_NONSECURE = 2'd1,
        SEC_ROOT      = 2'd2,
        SEC_REALM     = 2'd3
    } sec_state_e;

    // Permission codes held per SGI
    localparam logic [FIELD_W-1:0] CODE_NONE = 2'b00;
    localparam logic [FIELD_W-1:0] CODE_G0   = 2'b01;
    localparam logic [FIELD_W-1:0] CODE_G0G1 = 2'b10;
    localparam logic [FIELD_W-1:0] CODE_RSVD = 2'b11;

    // Map the reserved code onto the widest valid grant
    function automatic logic [FIELD_W-1:0] norm_code(input logic [FIELD_W-1:0] c);
        return (c == CODE_RSVD) ? CODE_G0G1 : c;
    endfunction

endpackage

// File: rtl/sgi_nsacc_gate.sv
// Module: access gate. Decides whether a bus access may write or read the
// register. Assumes one access per cycle and a fixed byte offset.
module sgi_nsacc_gate
    import sgi_nsacc_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 16'h0E00
) (
    input  logic              sec_disable,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_sec,
    output logic              wr_en,
    output logic              rd_en,
    output logic              rd_req
);

    logic hit;
    logic state_ok;

    // Purpose: qualify the access by offset, security state and global disable
    always_comb begin
        hit      = bus_valid && (bus_addr == REG_OFFSET);
        state_ok = (bus_sec == SEC_SECURE) || (bus_sec == SEC_ROOT);
        wr_en    = hit && bus_write && state_ok && !sec_disable;
        rd_en    = hit && !bus_write && state_ok && !sec_disable;
        rd_req   = bus_valid && !bus_write;
    end

endmodule

// File: rtl/sgi_nsacc_store.sv
// Module: register storage with per-byte write enables.
// Assumes DATA_W is a multiple of 8. Resets to all-zero codes.
module sgi_nsacc_store #(
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output logic [DATA_W-1:0] reg_q
);

    for (genvar b = 0; b < STRB_W; b++) begin : g_lane
        // Purpose: hold one byte lane, updated only when its strobe is set
        always_ff @(posedge clk) begin
            if (!rst_n)
                reg_q[b*8 +: 8] <= '0;
            else if (wr_en && wstrb[b])
                reg_q[b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

endmodule

// File: rtl/sgi_nsacc_judge.sv
// Module: permission decision. Normalises every stored code and compares the
// selected one with the level the target group needs. Purely combinational.
// Assumes group bit 1 marks a non-secure target and bit 0 picks secure group 1.
module sgi_nsacc_judge
    import sgi_nsacc_pkg::*;
#(
    parameter int NUM_SGI = 16,
    localparam int DATA_W = NUM_SGI * FIELD_W,
    localparam int IDX_W  = $clog2(NUM_SGI)
) (
    input  logic [DATA_W-1:0] reg_q,
    input  logic [IDX_W-1:0]  sgi,
    input  logic [1:0]        group,
    input  logic              from_secure,
    output logic              allow
);

    logic [FIELD_W-1:0] level [NUM_SGI];
    logic [FIELD_W-1:0] sel;

    for (genvar i = 0; i < NUM_SGI; i++) begin : g_norm
        assign level[i] = norm_code(reg_q[i*FIELD_W +: FIELD_W]);
    end

    // Purpose: grant when the selected level covers the requested group
    always_comb begin
        sel = level[sgi];
        if (from_secure || group[1])
            allow = 1'b1;
        else if (!group[0])
            allow = (sel >= CODE_G0);
        else
            allow = (sel >= CODE_G0G1);
    end

endmodule

// File: rtl/sgi_nsacc_reg.sv
// Module: top of the secure SGI access permission register. Joins the access
// gate, the storage and the decision logic, and registers both responses.
// Assumes a single-beat bus with no back-pressure and one query per cycle.
module sgi_nsacc_reg
    import sgi_nsacc_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 16'h0E00,
    parameter int                NUM_SGI    = 16,
    localparam int DATA_W = NUM_SGI * FIELD_W,
    localparam int STRB_W = DATA_W / 8,
    localparam int IDX_W  = $clog2(NUM_SGI)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_disable,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_sec,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [STRB_W-1:0] bus_wstrb,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              chk_valid,
    input  logic [IDX_W-1:0]  chk_sgi,
    input  logic [1:0]        chk_group,
    input  logic              chk_from_secure,
    output logic              chk_rvalid,
    output logic              chk_allow
);

    logic              wr_en;
    logic              rd_en;
    logic              rd_req;
    logic              allow_c;
    logic [DATA_W-1:0] reg_q;

    sgi_nsacc_gate #(
        .ADDR_W    (ADDR_W),
        .REG_OFFSET(REG_OFFSET)
    ) i_gate (
        .sec_disable(sec_disable),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_sec    (bus_sec),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .rd_req     (rd_req)
    );

    sgi_nsacc_store #(
        .DATA_W(DATA_W)
    ) i_store (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .wdata(bus_wdata),
        .wstrb(bus_wstrb),
        .reg_q(reg_q)
    );

    sgi_nsacc_judge #(
        .NUM_SGI(NUM_SGI)
    ) i_judge (
        .reg_q      (reg_q),
        .sgi        (chk_sgi),
        .group      (chk_group),
        .from_secure(chk_from_secure),
        .allow      (allow_c)
    );

    // Purpose: return read data, zero for blocked reads, one cycle after request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_req;
            bus_rdata  <= rd_en ? reg_q : '0;
        end
    end

    // Purpose: register the permission decision one cycle after a query
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_rvalid <= 1'b0;
            chk_allow  <= 1'b0;
        end else begin
            chk_rvalid <= chk_valid;
            chk_allow  <= chk_valid && allow_c;
        end
    end

endmodule

// File: rtl/sgi_nsacc_chk.sv
// Module: assertion checker for sgi_nsacc_reg, attached through bind.
// Observes ports and the stored register word. Drives nothing.
module sgi_nsacc_chk #(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 16'h0E00,
    parameter int                DATA_W     = 32,
    parameter int                IDX_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_disable,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_sec,
    input logic              bus_rvalid,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              chk_valid,
    input logic [IDX_W-1:0]  chk_sgi,
    input logic [1:0]        chk_group,
    input logic              chk_from_secure,
    input logic              chk_rvalid,
    input logic              chk_allow,
    input logic [DATA_W-1:0] reg_q
);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_q == '0));

    a_r2_read_data: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !sec_disable && bus_addr == REG_OFFSET &&
         (bus_sec == 2'd0 || bus_sec == 2'd2))
        |=> (bus_rvalid && bus_rdata == $past(reg_q)));

    a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    a_r3_state_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (bus_sec == 2'd1 || bus_sec == 2'd3)) |=> $stable(reg_q));

    a_r3_state_raz: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (bus_sec == 2'd1 || bus_sec == 2'd3)) |=> (bus_rdata == '0));

    a_r4_disable_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && sec_disable) |=> $stable(reg_q));

    a_r4_disable_raz: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && sec_disable) |=> (bus_rdata == '0));

    a_r5_offset_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr != REG_OFFSET) |=> $stable(reg_q));

    a_r8_zero_denies: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_from_secure && !chk_group[1] && reg_q[chk_sgi*2 +: 2] == 2'b00)
        |=> (chk_rvalid && !chk_allow));

    a_r11_bypass_allows: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && (chk_from_secure || chk_group[1])) |=> (chk_rvalid && chk_allow));

    a_r12_resp_valid: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_rvalid);

endmodule

bind sgi_nsacc_reg sgi_nsacc_chk #(
    .ADDR_W    (ADDR_W),
    .REG_OFFSET(REG_OFFSET),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sec_disable    (sec_disable),
    .bus_valid      (bus_valid),
    .bus_write      (bus_write),
    .bus_addr       (bus_addr),
    .bus_sec        (bus_sec),
    .bus_rvalid     (bus_rvalid),
    .bus_rdata      (bus_rdata),
    .chk_valid      (chk_valid),
    .chk_sgi        (chk_sgi),
    .chk_group      (chk_group),
    .chk_from_secure(chk_from_secure),
    .chk_rvalid     (chk_rvalid),
    .chk_allow      (chk_allow),
    .reg_q          (reg_q)
);

// File: tb/test_sgi_nsacc_reg.sv
`timescale 1ns/1ps
// Bench: scoreboard. Driver tasks push expected responses, computed from a
// requirement-level model, into queues. A monitor pops and compares them.
module test_sgi_nsacc_reg;

    localparam logic [15:0] OFF = 16'h0E00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_disable = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_sec = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        chk_valid = 1'b0;
    logic [3:0]  chk_sgi = '0;
    logic [1:0]  chk_group = '0;
    logic        chk_from_secure = 1'b0;
    logic        chk_rvalid;
    logic        chk_allow;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] model = '0;
    logic [31:0] rd_exp_q[$];
    string       rd_tag_q[$];
    logic        ck_exp_q[$];
    string       ck_tag_q[$];

    always #4 clk = ~clk;

    sgi_nsacc_reg i_sgi_nsacc_reg (
        .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_sec(bus_sec), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .chk_valid(chk_valid), .chk_sgi(chk_sgi), .chk_group(chk_group),
        .chk_from_secure(chk_from_secure), .chk_rvalid(chk_rvalid), .chk_allow(chk_allow)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit access_ok(input logic [1:0] sec, input logic [15:0] addr);
        return !sec_disable && addr == OFF && (sec == 2'd0 || sec == 2'd2);
    endfunction

    function automatic bit exp_allow(input logic [3:0] sgi, input logic [1:0] grp, input bit fs);
        logic [1:0] c;
        c = model[2*sgi +: 2];
        if (c == 2'b11) c = 2'b10;
        if (fs || grp[1]) return 1'b1;
        if (grp[0] == 1'b0) return c != 2'b00;
        return c == 2'b10;
    endfunction

    // Driver for one bus access; updates the model and queues read results
    task automatic bus_op(input bit wr, input logic [1:0] sec, input logic [15:0] addr,
                          input logic [31:0] data, input logic [3:0] strb, input string tag);
        bus_valid = 1'b1; bus_write = wr; bus_sec = sec; bus_addr = addr;
        bus_wdata = data; bus_wstrb = strb;
        if (wr) begin
            if (access_ok(sec, addr))
                for (int b = 0; b < 4; b++)
                    if (strb[b]) model[b*8 +: 8] = data[b*8 +: 8];
        end else begin
            rd_exp_q.push_back(access_ok(sec, addr) ? model : 32'h0);
            rd_tag_q.push_back(tag);
        end
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    // Driver for one permission query
    task automatic query(input logic [3:0] sgi, input logic [1:0] grp, input bit fs, input string tag);
        chk_valid = 1'b1; chk_sgi = sgi; chk_group = grp; chk_from_secure = fs;
        ck_exp_q.push_back(exp_allow(sgi, grp, fs));
        ck_tag_q.push_back(tag);
        @(posedge clk); #1;
        chk_valid = 1'b0;
    endtask

    // Monitor: compare responses with the scoreboard away from the clock edge
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (rd_exp_q.size() == 0)
                check(1'b0, "R2 unexpected read response", bus_rdata, 32'h0);
            else begin
                logic [31:0] e;
                string t;
                e = rd_exp_q.pop_front();
                t = rd_tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
        if (rst_n && chk_rvalid) begin
            if (ck_exp_q.size() == 0)
                check(1'b0, "R12 unexpected decision", {31'h0, chk_allow}, 32'h0);
            else begin
                logic e;
                string t;
                e = ck_exp_q.pop_front();
                t = ck_tag_q.pop_front();
                check(chk_allow === e, t, {31'h0, chk_allow}, {31'h0, e});
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: no responses out of reset
        check(bus_rvalid === 1'b0, "R1 rvalid after reset", {31'h0, bus_rvalid}, 32'h0);
        check(chk_rvalid === 1'b0, "R1 chk_rvalid after reset", {31'h0, chk_rvalid}, 32'h0);
        @(posedge clk); #1;
        bus_op(0, 2'd0, OFF, 0, 0, "R1 reset value");
        query(4'd3, 2'd0, 0, "R1 reset denies group 0");
        query(4'd9, 2'd1, 0, "R1 reset denies group 1");

        // R2: secure and root read/write
        bus_op(1, 2'd0, OFF, 32'h9C6B_2D14, 4'hF, "R2");
        bus_op(0, 2'd0, OFF, 0, 0, "R2 secure read back");
        bus_op(1, 2'd2, OFF, 32'h1B2E_6A90, 4'hF, "R2");
        bus_op(0, 2'd2, OFF, 0, 0, "R2 root read back");

        // R3: non-secure and realm are read-as-zero, write-ignored
        bus_op(1, 2'd1, OFF, 32'hFFFF_FFFF, 4'hF, "R3");
        bus_op(0, 2'd1, OFF, 0, 0, "R3 non-secure reads zero");
        bus_op(1, 2'd3, OFF, 32'h0000_0000, 4'hF, "R3");
        bus_op(0, 2'd3, OFF, 0, 0, "R3 realm reads zero");
        bus_op(0, 2'd0, OFF, 0, 0, "R3 register unchanged");

        // R4: security-disable blocks everything
        sec_disable = 1'b1;
        bus_op(1, 2'd0, OFF, 32'h5555_5555, 4'hF, "R4");
        bus_op(0, 2'd0, OFF, 0, 0, "R4 secure reads zero when disabled");
        bus_op(0, 2'd2, OFF, 0, 0, "R4 root reads zero when disabled");
        sec_disable = 1'b0;
        bus_op(0, 2'd0, OFF, 0, 0, "R4 register unchanged");

        // R5: other offsets
        bus_op(1, 2'd0, OFF + 16'd4, 32'hAAAA_AAAA, 4'hF, "R5");
        bus_op(0, 2'd0, OFF + 16'd4, 0, 0, "R5 other offset reads zero");
        bus_op(0, 2'd0, OFF, 0, 0, "R5 register unchanged");

        // R6: partial strobes
        bus_op(1, 2'd0, OFF, 32'hE4E4_E4E4, 4'b0101, "R6");
        bus_op(0, 2'd0, OFF, 0, 0, "R6 strobe lanes 0 and 2");
        bus_op(1, 2'd2, OFF, 32'h0000_0000, 4'b1000, "R6");
        bus_op(0, 2'd0, OFF, 0, 0, "R6 strobe lane 3");

        // R7 and R10: reserved code read raw, decided as 0b10
        bus_op(1, 2'd0, OFF, 32'hFFFF_FFFF, 4'hF, "R7");
        bus_op(0, 2'd0, OFF, 0, 0, "R7 reserved code reads raw");
        query(4'd0, 2'd1, 0, "R10 reserved code allows group 1");
        query(4'd15, 2'd0, 0, "R10 reserved code allows group 0");

        // R8..R12: walk every SGI against a patterned register
        bus_op(1, 2'd0, OFF, 32'hE4E4_E4E4, 4'hF, "R12");
        for (int s = 0; s < 16; s++) begin
            for (int g = 0; g < 3; g++) begin
                for (int f = 0; f < 2; f++) begin
                    string t;
                    if (f == 1 || g == 2) t = "R11 bypass";
                    else case (s % 4)
                        0: t = "R8 R12 code 00";
                        1: t = "R9 R12 code 01";
                        default: t = "R10 R12 code 10/11";
                    endcase
                    query(s[3:0], g[1:0], f[0], $sformatf("%s sgi=%0d grp=%0d", t, s, g));
                end
            end
        end
        // R11: group code 3 also counts as non-secure
        bus_op(1, 2'd0, OFF, 32'h0, 4'hF, "R11");
        query(4'd5, 2'd3, 0, "R11 non-secure group with zero code");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rd_exp_q.size() == 0, "R2 read responses outstanding", rd_exp_q.size(), 0);
        check(ck_exp_q.size() == 0, "R12 decisions outstanding", ck_exp_q.size(), 0);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: an expired run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule